// File: doc/BRIEF.md
# Oscillator-Count Sample Capture Engine

This block digitises one analog quantity that has already been turned into eight oscillator pulse trains. The oscillators are tuned apart from one another and all follow the same input voltage. The block counts rising edges on each oscillator inside a short sample window. At the end of every window it runs a fixed closing sequence. First the oscillator gate goes low so that counting stops. Then the block waits a settle time so that the asynchronous counters come to rest. Then it copies all eight counts into a latch in one step, and finally it clears the counters for the next window.

A trigger starts one record of `DEPTH` samples. Each sample is the eight 8-bit counts placed side by side and written into a single-ported capture memory. Once the record is complete, a slow host reads the samples back by address. Each read returns the eight raw counts together with their sum, which serves as a composite sample value. The memory is written only while a record is being acquired and read only once it has finished.

Top module: `osc_adc_capture`

## Requirements
- R1: Each of the eight edge counters counts the rising edges of its own oscillator input while `osc_gate_o` is high and ignores edges while it is low. Each count is 8 bits and wraps modulo 256.
- R2: While busy, `osc_gate_o` stays high for exactly `WIN_CYC` system clocks in each window (default 1).
- R3: The settle length is the value on `settle_i` sampled when the trigger is accepted, raised to 2 if it is smaller. Between two windows of a record the gate stays low for exactly settle length + 1 clocks (the settle cycles plus one clear cycle).
- R4: The counts are latched only after the gate has been low for the whole settle time. The counters are cleared before the gate opens again, so every stored count covers exactly one window.
- R5: A trigger accepted while idle raises `busy_o` and `osc_gate_o` on the next clock edge. Exactly `DEPTH` (2048) windows follow, and the counts of window k are stored at address k.
- R6: A trigger that arrives while busy, or in a cycle where `rd_req_i` is high, is ignored. An ignored trigger neither restarts the record nor starts a new one.
- R7: Reset state: `busy_o`, `done_o`, `osc_gate_o` and `rd_valid_o` are all 0. `done_o` rises, and `busy_o` falls, on the clock edge that writes the last sample. `done_o` clears when the next trigger is accepted.
- R8: A read request while not busy and with `rd_addr_i` < `DEPTH` gives `rd_valid_o` = 1 and `rd_err_o` = 0 one clock later. Channel c's count appears on `rd_counts_o[8c+7:8c]`.
- R9: `rd_sum_o` is the 11-bit sum of the eight counts on `rd_counts_o`, with no overflow.
- R10: A read request with `rd_addr_i` >= `DEPTH` gives `rd_valid_o` = 1 and `rd_err_o` = 1 one clock later, with all counts and the sum equal to zero.
- R11: A read request made while busy is not served (`rd_valid_o` stays 0) and does not disturb the record being stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| osc_i | input | 8 | Oscillator pulse trains, asynchronous to the system clock |
| trig_i | input | 1 | Starts a record when accepted |
| settle_i | input | 4 | Settle length in clocks (minimum 2 applied) |
| rd_req_i | input | 1 | Host read request |
| rd_addr_i | input | 12 | Host read address |
| rd_valid_o | output | 1 | Read result valid |
| rd_err_o | output | 1 | Read address was out of range |
| rd_counts_o | output | 64 | Eight packed 8-bit counts of the addressed sample |
| rd_sum_o | output | 11 | Sum of the eight counts |
| osc_gate_o | output | 1 | Gate enabling the oscillator counters |
| busy_o | output | 1 | Record acquisition in progress |
| done_o | output | 1 | A complete record is stored |

## Verification
A fault in the window sequencer shows at once on `osc_gate_o`. A wrong high or low run length is seen within one window period, and a restarted record shows as more than 2048 gate pulses before `done_o` rises. A stale or uncleared counter, or a latch taken too early, is not visible during acquisition. It first appears at readback, where the stored counts of the affected address differ from the edges the stimulus actually sent inside that window. Wrong lane packing or a wrong sum shows one clock after the first read request.

// File: rtl/osc_adc_pkg.sv
package osc_adc_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_COUNT  = 2'd1,
        SEQ_SETTLE = 2'd2,
        SEQ_CLEAR  = 2'd3
    } seq_state_e;

    localparam int unsigned MIN_SETTLE = 2;

endpackage

// File: rtl/osc_edge_counter.sv
module osc_edge_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             osc_i,
    input  logic             gate_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);

    // Counts in the oscillator's own domain; clear is asynchronous and only
    // raised by the sequencer while the gate is low.
    always_ff @(posedge osc_i or posedge clr_i) begin
        if (clr_i) begin
            cnt_o <= '0;
        end else if (gate_i) begin
            cnt_o <= cnt_o + CNT_W'(1);
        end
    end

endmodule

// File: rtl/osc_window_seq.sv
module osc_window_seq
    import osc_adc_pkg::*;
#(
    parameter int unsigned DEPTH   = 2048,
    parameter int unsigned WIN_CYC = 1,
    parameter int unsigned SET_W   = 4,
    localparam int unsigned PTR_W  = $clog2(DEPTH),
    localparam int unsigned WT_W   = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1,
    localparam int unsigned TMR_W  = ((WT_W > SET_W) ? WT_W : SET_W) + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             trig_i,
    input  logic             hold_i,
    input  logic [SET_W-1:0] settle_i,
    output logic             gate_o,
    output logic             clr_o,
    output logic             latch_o,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_addr_o,
    output logic             busy_o,
    output logic             done_o
);

    typedef struct packed {
        seq_state_e       state;
        logic [TMR_W-1:0] tmr;
        logic [SET_W-1:0] settle_len;
        logic [PTR_W-1:0] ptr;
        logic             gate;
        logic             clr;
        logic             busy;
        logic             done;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            SEQ_IDLE: begin
                if (trig_i && !hold_i) begin
                    seq_d.state      = SEQ_COUNT;
                    seq_d.tmr        = TMR_W'(WIN_CYC - 1);
                    seq_d.settle_len = (settle_i < SET_W'(MIN_SETTLE)) ?
                                       SET_W'(MIN_SETTLE) : settle_i;
                    seq_d.ptr        = '0;
                    seq_d.gate       = 1'b1;
                    seq_d.busy       = 1'b1;
                    seq_d.done       = 1'b0;
                end
            end
            SEQ_COUNT: begin
                if (seq_q.tmr == '0) begin
                    seq_d.state = SEQ_SETTLE;
                    seq_d.gate  = 1'b0;
                    seq_d.tmr   = TMR_W'(seq_q.settle_len) - TMR_W'(1);
                end else begin
                    seq_d.tmr = seq_q.tmr - TMR_W'(1);
                end
            end
            SEQ_SETTLE: begin
                if (seq_q.tmr == '0) begin
                    seq_d.state = SEQ_CLEAR;
                    seq_d.clr   = 1'b1;
                end else begin
                    seq_d.tmr = seq_q.tmr - TMR_W'(1);
                end
            end
            SEQ_CLEAR: begin
                seq_d.clr = 1'b0;
                if (seq_q.ptr == PTR_W'(DEPTH - 1)) begin
                    seq_d.state = SEQ_IDLE;
                    seq_d.busy  = 1'b0;
                    seq_d.done  = 1'b1;
                end else begin
                    seq_d.state = SEQ_COUNT;
                    seq_d.ptr   = seq_q.ptr + PTR_W'(1);
                    seq_d.gate  = 1'b1;
                    seq_d.tmr   = TMR_W'(WIN_CYC - 1);
                end
            end
            default: seq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{state: SEQ_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign gate_o    = seq_q.gate;
    assign clr_o     = seq_q.clr;
    assign latch_o   = (seq_q.state == SEQ_SETTLE) && (seq_q.tmr == '0);
    assign wr_en_o   = (seq_q.state == SEQ_CLEAR);
    assign wr_addr_o = seq_q.ptr;
    assign busy_o    = seq_q.busy;
    assign done_o    = seq_q.done;

    assert_gate_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !gate_o);
    assert_latch_settled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        latch_o |-> (!gate_o && $past(!gate_o)));
    assert_clear_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_o |-> !gate_o);
    assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);
    assert_no_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> (!busy_o || (wr_addr_o >= $past(wr_addr_o))));

endmodule

// File: rtl/osc_sample_store.sv
module osc_sample_store #(
    parameter int unsigned NUM_OSC = 8,
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned DEPTH   = 2048,
    localparam int unsigned PTR_W  = $clog2(DEPTH),
    localparam int unsigned ADDR_W = PTR_W + 1,
    localparam int unsigned WORD_W = NUM_OSC * CNT_W,
    localparam int unsigned SUM_W  = CNT_W + $clog2(NUM_OSC)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_addr_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              rd_valid_o,
    output logic              rd_err_o,
    output logic [WORD_W-1:0] rd_counts_o,
    output logic [SUM_W-1:0]  rd_sum_o
);

    typedef struct packed {
        logic valid;
        logic err;
    } rsp_t;

    rsp_t rsp_d, rsp_q;
    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] word_q;
    logic              in_range;

    assign in_range = (rd_addr_i < ADDR_W'(DEPTH));

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = rd_en_i;
        rsp_d.err   = rd_en_i && !in_range;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    // Single port: writes only while acquiring, reads only while idle.
    always_ff @(posedge clk_i) begin
        if (wr_en_i) begin
            mem[wr_addr_i] <= wr_data_i;
        end else if (rd_en_i) begin
            word_q <= in_range ? mem[rd_addr_i[PTR_W-1:0]] : '0;
        end
    end

    always_comb begin
        rd_sum_o = '0;
        for (int i = 0; i < NUM_OSC; i++) begin
            rd_sum_o = rd_sum_o + SUM_W'(word_q[i*CNT_W +: CNT_W]);
        end
    end

    assign rd_valid_o  = rsp_q.valid;
    assign rd_err_o    = rsp_q.err;
    assign rd_counts_o = rsp_q.valid ? word_q : '0;

    assert_single_port_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && rd_en_i));
    assert_err_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_valid_o && rd_err_o) |-> (rd_sum_o == '0));

endmodule

// File: rtl/osc_adc_capture.sv
module osc_adc_capture #(
    parameter int unsigned NUM_OSC = 8,
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned DEPTH   = 2048,
    parameter int unsigned WIN_CYC = 1,
    parameter int unsigned SET_W   = 4,
    localparam int unsigned PTR_W  = $clog2(DEPTH),
    localparam int unsigned ADDR_W = PTR_W + 1,
    localparam int unsigned WORD_W = NUM_OSC * CNT_W,
    localparam int unsigned SUM_W  = CNT_W + $clog2(NUM_OSC)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_OSC-1:0] osc_i,
    input  logic              trig_i,
    input  logic [SET_W-1:0]  settle_i,
    input  logic              rd_req_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              rd_valid_o,
    output logic              rd_err_o,
    output logic [WORD_W-1:0] rd_counts_o,
    output logic [SUM_W-1:0]  rd_sum_o,
    output logic              osc_gate_o,
    output logic              busy_o,
    output logic              done_o
);

    logic              clr_seq;
    logic              clr_cnt;
    logic              latch_en;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_addr;
    logic [WORD_W-1:0] cnt_bus;
    logic [WORD_W-1:0] latch_d, latch_q;
    logic              rd_en;

    assign clr_cnt = clr_seq | ~rst_ni;
    assign rd_en   = rd_req_i & ~busy_o;

    osc_window_seq #(
        .DEPTH   (DEPTH),
        .WIN_CYC (WIN_CYC),
        .SET_W   (SET_W)
    ) u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .trig_i    (trig_i),
        .hold_i    (rd_req_i),
        .settle_i  (settle_i),
        .gate_o    (osc_gate_o),
        .clr_o     (clr_seq),
        .latch_o   (latch_en),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    for (genvar g = 0; g < NUM_OSC; g++) begin : g_lane
        osc_edge_counter #(.CNT_W(CNT_W)) u_cnt (
            .osc_i  (osc_i[g]),
            .gate_i (osc_gate_o),
            .clr_i  (clr_cnt),
            .cnt_o  (cnt_bus[g*CNT_W +: CNT_W])
        );
    end

    // Parallel latch of all counter bits once the settle time has elapsed.
    always_comb begin
        latch_d = latch_q;
        if (latch_en) begin
            latch_d = cnt_bus;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            latch_q <= '0;
        end else begin
            latch_q <= latch_d;
        end
    end

    osc_sample_store #(
        .NUM_OSC (NUM_OSC),
        .CNT_W   (CNT_W),
        .DEPTH   (DEPTH)
    ) u_store (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (latch_q),
        .rd_en_i     (rd_en),
        .rd_addr_i   (rd_addr_i),
        .rd_valid_o  (rd_valid_o),
        .rd_err_o    (rd_err_o),
        .rd_counts_o (rd_counts_o),
        .rd_sum_o    (rd_sum_o)
    );

    assert_busy_read_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> !rd_valid_o);
    assert_trig_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trig_i && !rd_req_i && !busy_o) |=> (busy_o && osc_gate_o));

endmodule

// File: tb/tb_osc_adc_capture.sv
`timescale 1ns/100ps
module tb_osc_adc_capture;

    localparam int DEPTH = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  osc = '0;
    logic        trig = 1'b0;
    logic [3:0]  settle = '0;
    logic        rd_req = 1'b0;
    logic [11:0] rd_addr = '0;
    logic        rd_valid, rd_err, gate, busy, done;
    logic [63:0] rd_counts;
    logic [10:0] rd_sum;

    int n_checks = 0;
    int n_fail = 0;
    int osc_mode = 0;
    int unsigned edge_cnt [8];
    logic [63:0] exp_mem [DEPTH];
    int win_n = 0;
    int exp_low = 3;
    bit mon_en = 0;
    bit seen_fall = 0;
    int run_len = 0;
    logic prev_gate = 1'b0;

    osc_adc_capture dut (
        .clk_i(clk), .rst_ni(rst_n), .osc_i(osc), .trig_i(trig),
        .settle_i(settle), .rd_req_i(rd_req), .rd_addr_i(rd_addr),
        .rd_valid_o(rd_valid), .rd_err_o(rd_err), .rd_counts_o(rd_counts),
        .rd_sum_o(rd_sum), .osc_gate_o(gate), .busy_o(busy), .done_o(done)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [10:0] sum_of(input logic [63:0] w);
        logic [10:0] s = '0;
        for (int i = 0; i < 8; i++) s = s + 11'(w[i*8 +: 8]);
        return s;
    endfunction

    // Oscillator model: edges at half-nanosecond offsets, never on a clock edge.
    initial begin
        #0.5;
        forever begin
            #1;
            for (int c = 0; c < 8; c++) begin
                bit tog;
                case (osc_mode)
                    1: tog = (($urandom % 8) < (c + 1));
                    2: tog = 1'b1;
                    default: tog = 1'b0;
                endcase
                if (tog) begin
                    osc[c] = ~osc[c];
                    if (osc[c] && gate) edge_cnt[c]++;
                end
            end
        end
    end

    always @(posedge gate) begin
        for (int c = 0; c < 8; c++) edge_cnt[c] = 0;
    end

    // R1 expectation: rising edges seen while the gate was open, modulo 256.
    always @(negedge gate) begin
        if (win_n < DEPTH) begin
            for (int c = 0; c < 8; c++) exp_mem[win_n][c*8 +: 8] = 8'(edge_cnt[c]);
        end
        win_n++;
    end

    // Gate run-length monitor for R2 and R3.
    always @(negedge clk) begin
        if (mon_en) begin
            if (gate === prev_gate) begin
                run_len++;
            end else begin
                if (prev_gate) begin
                    check("R2 gate high length", 64'(run_len), 64'd1);
                    seen_fall = 1;
                end else if (seen_fall) begin
                    check("R3 gate low length", 64'(run_len), 64'(exp_low));
                end
                run_len = 1;
            end
        end
        prev_gate = gate;
    end

    task automatic read_check(input int a);
        @(negedge clk);
        rd_req = 1'b1;
        rd_addr = 12'(a);
        @(negedge clk);
        check("R8 read valid", 64'(rd_valid), 64'd1);
        if (a < DEPTH) begin
            check("R8 read err", 64'(rd_err), 64'd0);
            check("R1 R4 stored counts", rd_counts, exp_mem[a]);
            check("R9 sum", 64'(rd_sum), 64'(sum_of(exp_mem[a])));
        end else begin
            check("R10 err flag", 64'(rd_err), 64'd1);
            check("R10 zero counts", rd_counts, 64'd0);
            check("R10 zero sum", 64'(rd_sum), 64'd0);
        end
        rd_req = 1'b0;
    endtask

    task automatic run_record(input logic [3:0] s, input int mode, input bit poke);
        osc_mode = mode;
        exp_low = ((s < 2) ? 2 : int'(s)) + 1;
        win_n = 0;
        seen_fall = 0;
        @(negedge clk);
        settle = s;
        trig = 1'b1;
        mon_en = 1;
        @(negedge clk);
        trig = 1'b0;
        check("R5 busy after trigger", 64'(busy), 64'd1);
        check("R5 gate after trigger", 64'(gate), 64'd1);
        check("R7 done cleared by trigger", 64'(done), 64'd0);
        settle = 4'd9;
        if (poke) begin
            repeat (37) @(negedge clk);
            trig = 1'b1;
            @(negedge clk);
            trig = 1'b0;
            repeat (5) @(negedge clk);
            rd_req = 1'b1;
            rd_addr = 12'd3;
            @(negedge clk);
            check("R11 no read while busy", 64'(rd_valid), 64'd0);
            rd_req = 1'b0;
        end
        while (busy) @(negedge clk);
        mon_en = 0;
        check("R7 done at end", 64'(done), 64'd1);
        check("R5 R6 window count", 64'(win_n), 64'(DEPTH));
        for (int a = 0; a < DEPTH; a++) read_check(a);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R7 reset busy", 64'(busy), 64'd0);
        check("R7 reset done", 64'(done), 64'd0);
        check("R7 reset gate", 64'(gate), 64'd0);
        check("R7 reset valid", 64'(rd_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        read_check(2048);

        run_record(4'd0, 2, 1'b0);
        read_check(4095);

        @(negedge clk);
        rd_req = 1'b1;
        rd_addr = 12'd0;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        rd_req = 1'b0;
        check("R6 trigger during read ignored", 64'(busy), 64'd0);
        check("R6 gate stays closed", 64'(gate), 64'd0);
        check("R7 done kept", 64'(done), 64'd1);

        run_record(4'd7, 1, 1'b1);
        run_record(4'd3, 0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule